// File: doc/BRIEF.md
# Guarded Vector-Select Control Register

This block is an 8-bit control register that sits on a plain write/read register bus. It holds three external-interrupt line enables, a single vector-select bit that tells the interrupt logic which of two vector-table bases to use, and an unlock bit. The vector-select bit is protected. To change it, software first writes a 1 to the unlock bit. That opens a short window, timed in clock cycles. Within the window, software writes the new select value with the unlock bit at 0. Writes made at any other time leave the select bit alone. The enable bits stay ordinary read/write fields at all times.

While the unlock window is open, the block raises a hold output that tells the interrupt logic to withhold interrupt entry. The hold also covers the instruction that follows an accepted select write. An instruction-boundary input marks when that instruction ends. The hold is a separate output. The block has no connection to the processor's global interrupt-enable flag, so that flag is never modified. The block does not compute vector addresses; it only supplies the select bit.

Top module: `vecsel_lock_reg`

## Requirements
- R1: After reset, rd_data reads 0x00 and irq_hold is 0.
- R2: rd_data is laid out as bits 7:5 the enables, bits 4:2 reserved, bit 1 the vector select and bit 0 the unlock flag. Bits 4:2 always read 0, even after a write of 1s to them.
- R3: Every write loads wr_data[7:5] into the enable field, visible on the next cycle, whether or not the window is open. The mapping is irq_en[2] = bit 7 (line 1), irq_en[1] = bit 6 (line 0) and irq_en[0] = bit 5 (line 2).
- R4: A write with bit 0 = 1 sets the unlock flag from the next cycle. The flag then reads 1 for exactly WINDOW cycles (4 by default) and drops to 0 by itself, unless it is re-armed or a select write is accepted first.
- R5: A write with bit 0 = 0, made in a cycle where the unlock flag reads 1, loads wr_data[1] into the vector select. The same write clears the unlock flag. Both changes appear on the next cycle. This includes a write made in the last cycle of the window.
- R6: The vector select keeps its value after a write made while the unlock flag reads 0, and after any write with bit 0 = 1.
- R7: A write with bit 0 = 1 while the window is open restarts the count, so the flag reads 1 for WINDOW cycles counted from that write.
- R8: irq_hold is 1 in every cycle in which the unlock flag reads 1. It rises in the cycle after the arming write.
- R9: After an accepted select write, irq_hold stays 1 until the first clock edge after the accepting edge that samples insn_done = 1. irq_hold is 0 from the following cycle. An insn_done sampled on the accepting edge itself does not end the hold. If the window expires without a select write, irq_hold falls together with the unlock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_data | input | 8 | Write data |
| insn_done | input | 1 | High in the cycle an instruction completes |
| rd_data | output | 8 | Current register contents |
| irq_en | output | 3 | External-interrupt line enables |
| vec_sel | output | 1 | Current vector-table select |
| irq_hold | output | 1 | Withhold interrupt entry while high |

## Verification
The unlock path is driven with several patterns. A select write inside the window shows that acceptance works. The same write after the window has expired shows that the lock holds. An arming write that carries bit 1 = 1 shows that arming never loads the select. A select write in the last cycle of the window checks the edge of the window. A re-arm part way through the window is checked for the cycle in which the flag falls, which separates a count that restarts from one that runs on. The hold tail is tried with insn_done both on the accepting edge and on later edges, which separates "the following instruction" from "the current one". A reset in the middle of a window confirms that all state is cleared.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

   localparam int EN_W     = 3;
   localparam int EN_LSB   = 5;
   localparam int VSEL_BIT = 1;
   localparam int CHG_BIT  = 0;

   typedef struct packed {
      logic [EN_W-1:0] en;
      logic [2:0]      rsv;
      logic            vsel;
      logic            chg;
   } vsr_reg_t;

endpackage

// File: rtl/vsr_window.sv
module vsr_window #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic take,
   output logic open_o
);

   localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (arm) begin
         open_q <= 1'b1;
         cnt_q  <= CNT_W'(WINDOW - 1);
      end else if (take) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (open_q) begin
         if (cnt_q == '0) open_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign open_o = open_q;

endmodule

// File: rtl/vsr_tail.sv
module vsr_tail #(
   parameter int TAIL_INSNS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic insn_done,
   output logic busy
);

   generate
      if (TAIL_INSNS == 1) begin : g_flag
         logic busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         busy_q <= 1'b0;
            else if (start)     busy_q <= 1'b1;
            else if (insn_done) busy_q <= 1'b0;
         end
         assign busy = busy_q;
      end else begin : g_cnt
         localparam int TW = $clog2(TAIL_INSNS + 1);
         logic [TW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                          left_q <= '0;
            else if (start)                      left_q <= TW'(TAIL_INSNS);
            else if (insn_done && left_q != '0)  left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/vecsel_lock_reg.sv
module vecsel_lock_reg
   import vsr_pkg::*;
#(
   parameter int WINDOW     = 4,
   parameter int TAIL_INSNS = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       insn_done,
   output logic [7:0] rd_data,
   output logic [2:0] irq_en,
   output logic       vec_sel,
   output logic       irq_hold
);

   initial begin
      if (WINDOW < 1)     $error("WINDOW must be at least 1");
      if (TAIL_INSNS < 1) $error("TAIL_INSNS must be at least 1");
      if ($bits(vsr_reg_t) != 8) $error("register layout must be 8 bits");
   end

   logic            arm, take, win_open, tail_busy;
   logic [EN_W-1:0] en_q;
   logic            vsel_q;
   logic            rsv_unused;
   vsr_reg_t        rd_f;

   assign rsv_unused = ^wr_data[4:2];

   assign arm  = wr_en &  wr_data[CHG_BIT];
   assign take = wr_en & ~wr_data[CHG_BIT] & win_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         vsel_q <= 1'b0;
      end else begin
         if (wr_en) en_q   <= wr_data[EN_LSB +: EN_W];
         if (take)  vsel_q <= wr_data[VSEL_BIT];
      end
   end

   vsr_window #(.WINDOW(WINDOW)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .take   (take),
      .open_o (win_open)
   );

   vsr_tail #(.TAIL_INSNS(TAIL_INSNS)) u_tail (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (take),
      .insn_done (insn_done),
      .busy      (tail_busy)
   );

   always_comb begin
      rd_f.en   = en_q;
      rd_f.rsv  = 3'b000;
      rd_f.vsel = vsel_q;
      rd_f.chg  = win_open;
   end

   assign rd_data  = rd_f;
   assign irq_en   = en_q;
   assign vec_sel  = vsel_q;
   assign irq_hold = win_open | tail_busy;

endmodule

// File: rtl/vecsel_lock_reg_chk.sv
module vecsel_lock_reg_chk #(
   parameter int WINDOW = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       insn_done,
   input logic [7:0] rd_data,
   input logic [2:0] irq_en,
   input logic       vec_sel,
   input logic       irq_hold
);

   int run_q;
   logic ins_unused;
   assign ins_unused = insn_done;

   always_ff @(posedge clk) begin
      if (!rst_n)                    run_q <= 0;
      else if (wr_en && wr_data[0])  run_q <= 0;
      else if (rd_data[0])           run_q <= run_q + 1;
      else                           run_q <= 0;
   end

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4:2] == 3'b000);                                         // R2

   AST_EN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> irq_en == $past(wr_data[7:5]));                        // R3

   AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[0] |=> rd_data[0]);                             // R4

   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] |-> run_q < WINDOW);                                  // R7

   AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] && wr_en && !wr_data[0] |=>
         (vec_sel == $past(wr_data[1])) && !rd_data[0]);              // R5

   AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_data[0] && wr_en && !wr_data[0]) |=> $stable(vec_sel));     // R6

   AST_HOLD_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] |-> irq_hold);                                        // R8

   AST_TAIL_START: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] && wr_en && !wr_data[0] |=> irq_hold);                // R9

endmodule

bind vecsel_lock_reg vecsel_lock_reg_chk #(.WINDOW(WINDOW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .insn_done (insn_done),
   .rd_data   (rd_data),
   .irq_en    (irq_en),
   .vec_sel   (vec_sel),
   .irq_hold  (irq_hold)
);

// File: tb/vecsel_lock_reg_bench.sv
`timescale 1ns/1ps
module vecsel_lock_reg_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       insn_done = 1'b0;
   logic [7:0] rd_data;
   logic [2:0] irq_en;
   logic       vec_sel;
   logic       irq_hold;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   vecsel_lock_reg u_vecsel_lock_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .insn_done(insn_done), .rd_data(rd_data), .irq_en(irq_en),
      .vec_sel(vec_sel), .irq_hold(irq_hold)
   );

   // fields: [22:19] req, [18] we, [17:10] wd, [9] idn, [8:1] exp rd, [0] exp hold
   localparam int NV = 37;
   localparam logic [22:0] VEC [NV] = '{
      {4'd3, 1'b1, 8'hE0, 1'b0, 8'hE0, 1'b0},  // R3 enables load
      {4'd6, 1'b1, 8'hE3, 1'b0, 8'hE1, 1'b1},  // R6 arming write with bit1 set
      {4'd4, 1'b0, 8'h00, 1'b0, 8'hE1, 1'b1},  // R4 window open
      {4'd5, 1'b1, 8'hE2, 1'b0, 8'hE2, 1'b1},  // R5 accepted select
      {4'd9, 1'b0, 8'h00, 1'b0, 8'hE2, 1'b1},  // R9 tail
      {4'd9, 1'b0, 8'h00, 1'b1, 8'hE2, 1'b0},  // R9 ends on boundary
      {4'd9, 1'b0, 8'h00, 1'b0, 8'hE2, 1'b0},
      {4'd4, 1'b1, 8'h01, 1'b0, 8'h03, 1'b1},  // R4 arm, enables cleared
      {4'd8, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},  // R8
      {4'd8, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd4, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd4, 1'b0, 8'h00, 1'b0, 8'h02, 1'b0},  // R4 expiry after 4
      {4'd6, 1'b1, 8'h00, 1'b0, 8'h02, 1'b0},  // R6 late write ignored
      {4'd2, 1'b1, 8'h1C, 1'b0, 8'h02, 1'b0},  // R2 reserved read 0
      {4'd7, 1'b1, 8'h01, 1'b0, 8'h03, 1'b1},  // R7 arm
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd7, 1'b1, 8'h01, 1'b0, 8'h03, 1'b1},  // R7 re-arm
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1},
      {4'd7, 1'b0, 8'h00, 1'b0, 8'h02, 1'b0},  // R7 closes 4 after re-arm
      {4'd4, 1'b1, 8'h01, 1'b0, 8'h03, 1'b1},
      {4'd6, 1'b1, 8'hA1, 1'b0, 8'hA3, 1'b1},  // R6 bit0=1 never loads select
      {4'd5, 1'b1, 8'hA0, 1'b0, 8'hA0, 1'b1},  // R5 select to 0
      {4'd9, 1'b0, 8'h00, 1'b0, 8'hA0, 1'b1},
      {4'd9, 1'b0, 8'h00, 1'b1, 8'hA0, 1'b0},
      {4'd4, 1'b1, 8'h01, 1'b0, 8'h01, 1'b1},
      {4'd4, 1'b0, 8'h00, 1'b0, 8'h01, 1'b1},
      {4'd4, 1'b0, 8'h00, 1'b0, 8'h01, 1'b1},
      {4'd4, 1'b0, 8'h00, 1'b0, 8'h01, 1'b1},
      {4'd5, 1'b1, 8'h02, 1'b0, 8'h02, 1'b1},  // R5 last window slot
      {4'd9, 1'b0, 8'h00, 1'b1, 8'h02, 1'b0},
      {4'd4, 1'b1, 8'h01, 1'b0, 8'h03, 1'b1},
      {4'd9, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1},  // R9 boundary on accept edge ignored
      {4'd9, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
      {4'd9, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic we, input logic [7:0] wd, input logic idn);
      wr_en = we; wr_data = wd; insn_done = idn;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_data = 8'h00; insn_done = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 rd", rd_data, 8'h00);
      check("R1 hold", {7'd0, irq_hold}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][18], VEC[i][17:10], VEC[i][9]);
         check($sformatf("R%0d rd step %0d", VEC[i][22:19], i), rd_data, VEC[i][8:1]);
         check($sformatf("R%0d hold step %0d", VEC[i][22:19], i),
               {7'd0, irq_hold}, {7'd0, VEC[i][0]});
      end

      // R3 bit mapping on the enable port
      cyc(1'b1, 8'h80, 1'b0);
      check("R3 line1 enable", {5'd0, irq_en}, 8'h04);
      cyc(1'b1, 8'h20, 1'b0);
      check("R3 line2 enable", {5'd0, irq_en}, 8'h01);
      check("R6 vec_sel kept", {7'd0, vec_sel}, 8'h00);

      // R1 reset in the middle of an open window
      cyc(1'b1, 8'hE1, 1'b0);
      check("R8 hold armed", {7'd0, irq_hold}, 8'h01);
      rst_n = 1'b0;
      cyc(1'b0, 8'h00, 1'b0);
      check("R1 rd after reset", rd_data, 8'h00);
      check("R1 hold after reset", {7'd0, irq_hold}, 8'h00);
      rst_n = 1'b1;
      cyc(1'b1, 8'h02, 1'b0);
      check("R6 closed after reset", rd_data, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule